// File: doc/BRIEF.md
# Software-Generated Interrupt Router

This block converts a single 64-bit write to one of three software interrupt generator registers into per-core delivery requests for a cluster of `NUM_CORES` processor cores. The write word is unpacked into an interrupt number, a 16-bit target list, a 24-bit cluster address and a routing-mode bit. Each core's configured four-level affinity is then compared against the write to find the cores that should receive the interrupt.

The interrupt group travelling with each delivery depends on three things: which generator register was written, whether the writing core is secure or non-secure, and a global security-disable control. The non-secure flag on every delivery is the writer's own security state. All selected cores receive a one-cycle delivery pulse in the same cycle, one clock after the write strobe. The interrupt number, group and flag are shared by all cores and are valid in that cycle.

Top module: `sgi_router`

## Requirements
- R1: While reset is held and in the first cycle after it, `dlv_valid_o`, `dlv_intid_o`, `dlv_group_o` and `dlv_ns_o` are all zero.
- R2: With bit 40 of the write data clear, core i is targeted when two conditions hold. First, its Aff3, Aff2 and Aff1 (bits 31:24, 23:16 and 15:8 of slice i of `core_aff_i`) equal data bits 55:48, 39:32 and 23:16. Second, target-list bit n of data bits 15:0 is set, where n is the core's Aff0 (bits 7:0 of the slice).
- R3: With bit 40 clear, a core whose Aff0 is greater than 15 is never targeted.
- R4: With bit 40 set, every core except the one indexed by `wr_core_i` is targeted, and the target list and affinity fields have no effect. If `wr_core_i` indexes no core, every core is targeted.
- R5: `dlv_intid_o` carries data bits 27:24 of the write.
- R6: The group encoding is 0 for Group 0, 1 for Secure Group 1 and 2 for Non-secure Group 1. For selector 0, the group is 0. For selector 1, the group is 2 for a non-secure writer (`wr_ns_i`=1) and 1 for a secure writer. For selector 2, the group is 1 for a non-secure writer and 2 for a secure writer.
- R7: When `sec_dis_i` is 1, a resolved group of 1 is delivered as 0. Groups 0 and 2 are unchanged.
- R8: `dlv_ns_o` equals the writer's `wr_ns_i`, whichever selector is used.
- R9: Delivery pulses appear exactly one cycle after `wr_valid_i` and last one cycle. All targeted cores pulse together. No pulse appears in a cycle that does not follow a write.
- R10: A unicast write with an empty target list, or one that matches no core, produces no pulses.
- R11: Selector value 3 is reserved, and a write with it produces no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid_i | input | 1 | Single-cycle generator write strobe |
| wr_data_i | input | 64 | Packed generator write word |
| wr_sel_i | input | 2 | Generator register: 0 group 0, 1 group 1, 2 alternate group 1, 3 reserved |
| wr_core_i | input | CIDX_W | Index of the writing core |
| wr_ns_i | input | 1 | Writer is non-secure |
| sec_dis_i | input | 1 | Global security-disable control |
| core_aff_i | input | 32*NUM_CORES | Per-core affinity, slice i = {Aff3, Aff2, Aff1, Aff0} |
| dlv_valid_o | output | NUM_CORES | Per-core delivery pulse |
| dlv_intid_o | output | 4 | Interrupt number of the delivery |
| dlv_group_o | output | 2 | Interrupt group of the delivery |
| dlv_ns_o | output | 1 | Non-secure flag of the delivery |

## Verification
A corrupted target decision shows as a wrong bit in `dlv_valid_o` in the cycle right after the write. Examples are a mismatched cluster comparison, an Aff0 above 15 accepted, or the writer left in a broadcast. A wrong group mapping or a lost security-disable override shows on `dlv_group_o` in that same cycle. These faults do not accumulate over time: the block keeps no history beyond one register stage. For that reason every write is checked at its single result cycle, and the idle cycle after it is checked for stray pulses.

// File: rtl/sgi_router_pkg.sv
// Package: shared types and encodings for the software interrupt router.
// Assumes the fixed 64-bit generator word layout described in the brief.
package sgi_router_pkg;

    localparam int WORD_W   = 64;
    localparam int INTID_W  = 4;
    localparam int TLIST_W  = 16;
    localparam int AFFL_W   = 8;
    localparam int CLUS_W   = 3 * AFFL_W;
    localparam int CAFF_W   = 4 * AFFL_W;

    // Delivered interrupt group encoding
    typedef enum logic [1:0] {
        GRP_0      = 2'd0,
        GRP_1_SEC  = 2'd1,
        GRP_1_NSEC = 2'd2
    } grp_e;

    // Which generator register was written
    typedef enum logic [1:0] {
        SEL_GRP0   = 2'd0,
        SEL_GRP1   = 2'd1,
        SEL_ALT1   = 2'd2,
        SEL_RSVD   = 2'd3
    } sel_e;

    // Unpacked view of a generator write
    typedef struct packed {
        logic [INTID_W-1:0] intid;
        logic [CLUS_W-1:0]  cluster;
        logic [TLIST_W-1:0] tlist;
        logic               bcast;
    } sgi_word_t;

endpackage

// File: rtl/sgi_field_decode.sv
// Module: sgi_field_decode
// Splits the 64-bit generator word into its fields. Pure combinational.
// Assumes: cluster address ordered top level first (Aff3, Aff2, Aff1).
module sgi_field_decode
    import sgi_router_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output sgi_word_t         fields_o
);

    localparam int TLIST_LSB = 0;
    localparam int AFF1_LSB  = 16;
    localparam int INTID_LSB = 24;
    localparam int AFF2_LSB  = 32;
    localparam int BCAST_BIT = 40;
    localparam int AFF3_LSB  = 48;

    // Field extraction from fixed bit positions
    always_comb begin
        fields_o.tlist   = word_i[TLIST_LSB +: TLIST_W];
        fields_o.intid   = word_i[INTID_LSB +: INTID_W];
        fields_o.bcast   = word_i[BCAST_BIT];
        fields_o.cluster = {word_i[AFF3_LSB +: AFFL_W],
                            word_i[AFF2_LSB +: AFFL_W],
                            word_i[AFF1_LSB +: AFFL_W]};
    end

endmodule

// File: rtl/sgi_group_resolve.sv
// Module: sgi_group_resolve
// Maps generator register, writer security state and the security-disable
// control to the delivered interrupt group. Pure combinational.
// Assumes: the reserved selector yields group 0 (it is never delivered).
module sgi_group_resolve
    import sgi_router_pkg::*;
(
    input  logic [1:0] sel_i,
    input  logic       ns_i,
    input  logic       sec_dis_i,
    output logic [1:0] group_o,
    output logic       sel_ok_o
);

    grp_e raw_grp;

    // Group chosen by register variant and writer security state
    always_comb begin
        unique case (sel_e'(sel_i))
            SEL_GRP0: raw_grp = GRP_0;
            SEL_GRP1: raw_grp = ns_i ? GRP_1_NSEC : GRP_1_SEC;
            SEL_ALT1: raw_grp = ns_i ? GRP_1_SEC  : GRP_1_NSEC;
            default:  raw_grp = GRP_0;
        endcase
    end

    // Security-disable folds secure group 1 into group 0
    always_comb begin
        if (sec_dis_i && raw_grp == GRP_1_SEC) begin
            group_o = GRP_0;
        end else begin
            group_o = raw_grp;
        end
    end

    // Flag the reserved selector so the top can suppress delivery
    always_comb sel_ok_o = (sel_e'(sel_i) != SEL_RSVD);

endmodule

// File: rtl/sgi_target_match.sv
// Module: sgi_target_match
// Decides whether one core is a target of the current write.
// Assumes: core affinity is packed {Aff3, Aff2, Aff1, Aff0}; is_self_i is
// high only for the writing core.
module sgi_target_match
    import sgi_router_pkg::*;
(
    input  logic [CAFF_W-1:0]  core_aff_i,
    input  sgi_word_t          fields_i,
    input  logic               is_self_i,
    output logic               hit_o
);

    logic [CLUS_W-1:0] my_cluster;
    logic [AFFL_W-1:0] my_aff0;
    logic              aff0_in_range;
    logic              uni_hit;

    // Split the core's own affinity into cluster address and level 0
    always_comb begin
        my_cluster = core_aff_i[CAFF_W-1 -: CLUS_W];
        my_aff0    = core_aff_i[AFFL_W-1:0];
    end

    // Level 0 must index a target-list bit to be reachable
    always_comb aff0_in_range = (my_aff0[AFFL_W-1:4] == '0);

    // Unicast: same cluster and own target-list bit set
    always_comb begin
        uni_hit = 1'b0;
        if (aff0_in_range && my_cluster == fields_i.cluster) begin
            uni_hit = fields_i.tlist[my_aff0[3:0]];
        end
    end

    // Final choice between broadcast-except-self and unicast
    always_comb hit_o = fields_i.bcast ? !is_self_i : uni_hit;

endmodule

// File: rtl/sgi_router.sv
// Module: sgi_router (top)
// Turns one generator write into simultaneous per-core delivery pulses,
// registered one cycle after the write strobe.
// Assumes: wr_valid_i is a single-cycle pulse; outputs other than
// dlv_valid_o are meaningful only while some dlv_valid_o bit is high.
module sgi_router
    import sgi_router_pkg::*;
#(
    parameter int NUM_CORES = 8,
    localparam int CIDX_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_valid_i,
    input  logic [WORD_W-1:0]           wr_data_i,
    input  logic [1:0]                  wr_sel_i,
    input  logic [CIDX_W-1:0]           wr_core_i,
    input  logic                        wr_ns_i,
    input  logic                        sec_dis_i,
    input  logic [NUM_CORES*CAFF_W-1:0] core_aff_i,
    output logic [NUM_CORES-1:0]        dlv_valid_o,
    output logic [INTID_W-1:0]          dlv_intid_o,
    output logic [1:0]                  dlv_group_o,
    output logic                        dlv_ns_o
);

    sgi_word_t              fields;
    logic [1:0]             grp_next;
    logic                   sel_ok;
    logic [NUM_CORES-1:0]   hit_vec;

    logic [NUM_CORES-1:0]   valid_q;
    logic [INTID_W-1:0]     intid_q;
    logic [1:0]             group_q;
    logic                   ns_q;

    sgi_field_decode u_decode (
        .word_i   (wr_data_i),
        .fields_o (fields)
    );

    sgi_group_resolve u_group (
        .sel_i     (wr_sel_i),
        .ns_i      (wr_ns_i),
        .sec_dis_i (sec_dis_i),
        .group_o   (grp_next),
        .sel_ok_o  (sel_ok)
    );

    // One matcher per core
    for (genvar gi = 0; gi < NUM_CORES; gi++) begin : g_core
        logic is_self;
        // Writer identity for broadcast exclusion
        always_comb is_self = (int'(wr_core_i) == gi);

        sgi_target_match u_match (
            .core_aff_i (core_aff_i[gi*CAFF_W +: CAFF_W]),
            .fields_i   (fields),
            .is_self_i  (is_self),
            .hit_o      (hit_vec[gi])
        );
    end

    // Register the delivery; pulses last a single cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            intid_q <= '0;
            group_q <= '0;
            ns_q    <= 1'b0;
        end else if (wr_valid_i) begin
            valid_q <= sel_ok ? hit_vec : '0;
            intid_q <= fields.intid;
            group_q <= grp_next;
            ns_q    <= wr_ns_i;
        end else begin
            valid_q <= '0;
        end
    end

    // Drive outputs from the register stage
    always_comb begin
        dlv_valid_o = valid_q;
        dlv_intid_o = intid_q;
        dlv_group_o = group_q;
        dlv_ns_o    = ns_q;
    end

endmodule

// File: rtl/sgi_router_chk.sv
// Module: sgi_router_chk
// Port-level temporal checks for sgi_router, attached by bind.
module sgi_router_chk #(
    parameter int NUM_CORES = 8,
    parameter int CIDX_W    = 3
)(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_valid_i,
    input logic [63:0]          wr_data_i,
    input logic [1:0]           wr_sel_i,
    input logic [CIDX_W-1:0]    wr_core_i,
    input logic                 wr_ns_i,
    input logic                 sec_dis_i,
    input logic [NUM_CORES-1:0] dlv_valid_o,
    input logic [3:0]           dlv_intid_o,
    input logic [1:0]           dlv_group_o,
    input logic                 dlv_ns_o
);

    logic [NUM_CORES-1:0] self_bit;

    // One-hot mask of the writer (zero if it indexes no core)
    always_comb self_bit = {{(NUM_CORES-1){1'b0}}, 1'b1} << wr_core_i;

    // R9
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid_i |=> (dlv_valid_o == '0));

    // R4
    bcast_skips_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_data_i[40] && wr_sel_i != 2'd3)
        |=> ((dlv_valid_o & $past(self_bit)) == '0));

    // R4
    bcast_reaches_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_data_i[40] && wr_sel_i != 2'd3)
        |=> ((dlv_valid_o | $past(self_bit)) == '1));

    // R5
    intid_carried_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> (dlv_intid_o == $past(wr_data_i[27:24])));

    // R6
    grp0_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_sel_i == 2'd0) |=> (dlv_group_o == 2'd0));

    // R7
    secdis_no_sec1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && sec_dis_i && wr_sel_i != 2'd3) |=> (dlv_group_o != 2'd1));

    // R8
    ns_follows_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_i |=> (dlv_ns_o == $past(wr_ns_i)));

    // R11
    rsvd_sel_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_sel_i == 2'd3) |=> (dlv_valid_o == '0));

endmodule

bind sgi_router sgi_router_chk #(
    .NUM_CORES (NUM_CORES),
    .CIDX_W    (CIDX_W)
) u_sgi_router_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .wr_sel_i    (wr_sel_i),
    .wr_core_i   (wr_core_i),
    .wr_ns_i     (wr_ns_i),
    .sec_dis_i   (sec_dis_i),
    .dlv_valid_o (dlv_valid_o),
    .dlv_intid_o (dlv_intid_o),
    .dlv_group_o (dlv_group_o),
    .dlv_ns_o    (dlv_ns_o)
);

// File: tb/sgi_router_bench.sv
module sgi_router_bench;

    localparam int N      = 8;
    localparam int CIDX_W = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            wr_valid_i;
    logic [63:0]     wr_data_i;
    logic [1:0]      wr_sel_i;
    logic [CIDX_W-1:0] wr_core_i;
    logic            wr_ns_i;
    logic            sec_dis_i;
    logic [N*32-1:0] core_aff_i;
    logic [N-1:0]    dlv_valid_o;
    logic [3:0]      dlv_intid_o;
    logic [1:0]      dlv_group_o;
    logic            dlv_ns_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5ns clk = ~clk;

    sgi_router #(.NUM_CORES(N)) u_sgi_router (
        .clk (clk), .rst_n (rst_n),
        .wr_valid_i (wr_valid_i), .wr_data_i (wr_data_i),
        .wr_sel_i (wr_sel_i), .wr_core_i (wr_core_i),
        .wr_ns_i (wr_ns_i), .sec_dis_i (sec_dis_i),
        .core_aff_i (core_aff_i),
        .dlv_valid_o (dlv_valid_o), .dlv_intid_o (dlv_intid_o),
        .dlv_group_o (dlv_group_o), .dlv_ns_o (dlv_ns_o)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Build a generator word; unused bits filled with random junk
    function automatic logic [63:0] mk(input logic [3:0] intid, input logic [7:0] a3,
                                       input logic [7:0] a2, input logic [7:0] a1,
                                       input logic bc, input logic [15:0] tl);
        logic [63:0] w;
        w = {$urandom, $urandom};
        w[15:0]  = tl;
        w[23:16] = a1;
        w[27:24] = intid;
        w[39:32] = a2;
        w[40]    = bc;
        w[55:48] = a3;
        return w;
    endfunction

    function automatic logic [N-1:0] exp_mask(input logic [63:0] w, input int core, input logic [1:0] sel);
        logic [N-1:0] m;
        m = '0;
        if (sel == 2'd3) return m;
        for (int i = 0; i < N; i++) begin
            logic [31:0] a;
            a = core_aff_i[i*32 +: 32];
            if (w[40]) m[i] = (i != core);
            else if (a[31:8] == {w[55:48], w[39:32], w[23:16]} && a[7:0] < 16)
                m[i] = w[a[3:0]];
        end
        return m;
    endfunction

    function automatic logic [1:0] exp_grp(input logic [1:0] sel, input logic ns, input logic sd);
        logic [1:0] g;
        case (sel)
            2'd1:    g = ns ? 2'd2 : 2'd1;
            2'd2:    g = ns ? 2'd1 : 2'd2;
            default: g = 2'd0;
        endcase
        if (sd && g == 2'd1) g = 2'd0;
        return g;
    endfunction

    // Drive one write at a negedge, check its result cycle and the idle cycle after
    task automatic send(input string tag, input logic [1:0] sel, input logic [63:0] w,
                        input int core, input logic ns, input logic sd);
        logic [N-1:0] em;
        em = exp_mask(w, core, sel);
        wr_valid_i = 1'b1; wr_data_i = w; wr_sel_i = sel;
        wr_core_i = CIDX_W'(core); wr_ns_i = ns; sec_dis_i = sd;
        @(negedge clk);
        wr_valid_i = 1'b0;
        chk({tag, " mask"}, 64'(dlv_valid_o), 64'(em));
        chk("R5 intid", 64'(dlv_intid_o), 64'(w[27:24]));
        chk("R8 ns", 64'(dlv_ns_o), 64'(ns));
        if (sel != 2'd3) chk("R6/R7 group", 64'(dlv_group_o), 64'(exp_grp(sel, ns, sd)));
        @(negedge clk);
        chk("R9 single pulse", 64'(dlv_valid_o), 64'd0);
    endtask

    initial begin
        #(200_000 * 10ns);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5617));
        rst_n = 1'b0; wr_valid_i = 1'b0; wr_data_i = '0; wr_sel_i = '0;
        wr_core_i = '0; wr_ns_i = 1'b0; sec_dis_i = 1'b0;
        // Cluster A = 1.2.3 cores 0..3 aff0 0..3, core 7 aff0 9;
        // cluster B = 0.0.5 cores 4,5 aff0 7,15; core 6 aff0 16 (out of range)
        core_aff_i = {32'h01020309, 32'h00000510, 32'h0000050F, 32'h00000507,
                      32'h01020303, 32'h01020302, 32'h01020301, 32'h01020300};
        // R1: outputs zero during reset
        @(negedge clk); @(negedge clk);
        chk("R1 valid in reset", 64'(dlv_valid_o), 0);
        chk("R1 fields in reset", 64'({dlv_intid_o, dlv_group_o, dlv_ns_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({dlv_valid_o, dlv_intid_o, dlv_group_o, dlv_ns_o}), 0);

        // Directed corners
        send("R2 cluster A", 2'd1, mk(4'h3, 8'h01, 8'h02, 8'h03, 1'b0, 16'h0205), 0, 1'b1, 1'b0);
        send("R3 aff0>15 core6", 2'd0, mk(4'h7, 8'h00, 8'h00, 8'h05, 1'b0, 16'hFFFF), 4, 1'b0, 1'b0);
        send("R4 broadcast", 2'd2, mk(4'hA, 8'hEE, 8'hEE, 8'hEE, 1'b1, 16'h0000), 5, 1'b0, 1'b1);
        send("R4 broadcast w0", 2'd1, mk(4'h1, 8'h01, 8'h02, 8'h03, 1'b1, 16'hFFFF), 0, 1'b0, 1'b0);
        send("R10 empty list", 2'd1, mk(4'h2, 8'h01, 8'h02, 8'h03, 1'b0, 16'h0000), 1, 1'b0, 1'b0);
        send("R10 no cluster", 2'd0, mk(4'h2, 8'h09, 8'h02, 8'h03, 1'b0, 16'hFFFF), 1, 1'b0, 1'b0);
        send("R11 reserved sel", 2'd3, mk(4'h4, 8'h01, 8'h02, 8'h03, 1'b1, 16'hFFFF), 2, 1'b1, 1'b0);
        send("R7 secdis grp1 secure", 2'd1, mk(4'h5, 8'h00, 8'h00, 8'h05, 1'b0, 16'h8080), 0, 1'b0, 1'b1);
        send("R7 secdis alt ns", 2'd2, mk(4'h6, 8'h01, 8'h02, 8'h03, 1'b0, 16'h0001), 3, 1'b1, 1'b1);
        send("R6 alt secure", 2'd2, mk(4'h9, 8'h01, 8'h02, 8'h03, 1'b0, 16'h0200), 3, 1'b0, 1'b1);

        // Constrained random mix
        for (int k = 0; k < 400; k++) begin
            int c;
            logic [7:0] a3, a2, a1;
            c = $urandom_range(0, 2);
            if (c == 0)      begin a3 = 8'h01; a2 = 8'h02; a1 = 8'h03; end
            else if (c == 1) begin a3 = 8'h00; a2 = 8'h00; a1 = 8'h05; end
            else             begin a3 = 8'($urandom); a2 = 8'($urandom); a1 = 8'($urandom); end
            send("R2/R4 random", 2'($urandom), mk(4'($urandom), a3, a2, a1,
                 ($urandom_range(0, 3) == 0), 16'($urandom)),
                 $urandom_range(0, N-1), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule